// File: doc/BRIEF.md
# Hashed Page Table Insertion Engine

This block places one address translation into a hashed page table that lives in a single-port memory. A request carries a virtual address, a segment identifier and a physical frame number. The engine hashes the segment identifier with the page index to choose an 8-entry group. It then reads that group's entries one at a time, looking for a free slot or a slot that already holds the same translation. If the primary group has no such slot, a second group, selected by the complemented hash, is searched the same way. When both groups are full of other translations, a fixed slot in the primary group, chosen from the page index, is overwritten. The engine then writes one complete entry.

A host raises `start` for one cycle in which `busy` is low. It leaves the operands on the inputs for that cycle only, because the engine captures them then. The engine reports completion with a one-cycle `done`. The memory port carries one table entry per access and returns read data one cycle after the read request. The table base comes from the upper half of a configuration word.

Top module: `hpt_insert_engine`

## Requirements
- R1: The page index is `vaddr[27:12]`. The abbreviated page index is `vaddr[27:22]`, and it is stored in bits 29:24 of the written entry.
- R2: The primary group number is the low 10 bits of (`seg_id` XOR page index). Probing starts at slot 0 of that group, and the entry address is {base, group, slot}.
- R3: Slots are read in order 0 to 7. The first slot that qualifies is the one written, and no later slot is read. A slot qualifies when its valid bit (entry bit 55) is 0, or when it is valid with a segment field (bits 54:31) equal to `seg_id` and an abbreviated page field (bits 29:24) equal to the request's. A valid slot with equal segment but a different abbreviated page index does not qualify.
- R4: If no primary slot qualifies, the group given by the bitwise complement of the 10-bit hash is probed by the same rule. A slot taken there is written with the hash-select bit (entry bit 30) set to 1.
- R5: If neither group has a qualifying slot, the entry is written in the primary group at slot (page index mod 8) with the hash-select bit set to 0.
- R6: The written entry is {valid=1 [55], segment id [54:31], hash select [30], abbreviated page [29:24], frame [23:4], referenced=0 [3], changed=0 [2], protection=2 [1:0]}.
- R7: The upper 29-13=16 address bits are `table_cfg[31:16]` as captured at start. The low 16 configuration bits have no effect on any address.
- R8: The port issues at most one access per cycle. Read data is used one cycle after the request. Each insertion performs exactly one write, and `done` pulses for one cycle in the cycle after that write.
- R9: A `start` raised while `busy` is high is ignored. The running insertion keeps its captured operands, and no extra write follows.
- R10: An active-low reset returns the engine to idle with `busy`, `done` and `mem_req` low, and it abandons an insertion in progress without writing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an insertion (taken only when idle) |
| vaddr | input | 32 | Virtual address of the translation |
| seg_id | input | 24 | Segment identifier |
| frame | input | 20 | Physical frame number |
| table_cfg | input | 32 | Configuration word; upper 16 bits give the table base |
| busy | output | 1 | Insertion in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 29 | Entry address {base, group, slot} |
| mem_wdata | output | 56 | Entry to write |
| mem_rdata | input | 56 | Entry read, valid one cycle after a read request |

## Verification
The hardest case to reach from the ports is the fallback overwrite. To get there, all sixteen slots of both groups must hold valid entries that differ from the request, and the bench fills the memory model with exactly that pattern before starting. Secondary-group selection is reached the same way: the primary group is filled with foreign entries, and the secondary group is seeded with a near-miss entry (same segment, different abbreviated page) ahead of a free slot. A hash of all ones is included so that the secondary group wraps to group zero. Mid-run reset and a second start during the long fallback search are applied at chosen cycles while the memory traffic is watched.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_CHECK,
      ST_WRITE,
      ST_DONE
   } hpt_state_e;

   localparam int unsigned PROT_W    = 2;
   localparam logic [1:0]  PROT_INIT = 2'd2;
   localparam int unsigned FLAG_W    = 2 + PROT_W;

   function automatic int unsigned entry_width(int unsigned sid_w,
                                               int unsigned api_w,
                                               int unsigned pfn_w);
      return 1 + sid_w + 1 + api_w + pfn_w + FLAG_W;
   endfunction

endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
   parameter int unsigned PAGE_W     = 16,
   parameter int unsigned SID_W      = 24,
   parameter int unsigned API_W      = 6,
   parameter int unsigned GROUP_BITS = 10,
   parameter int unsigned WAY_BITS   = 3
) (
   input  logic [PAGE_W-1:0]     page,
   input  logic [SID_W-1:0]      sid,
   input  logic                  use_alt,
   output logic [GROUP_BITS-1:0] group,
   output logic [API_W-1:0]      api,
   output logic [WAY_BITS-1:0]   spill_slot
);

   logic [GROUP_BITS-1:0] hash;

   always_comb begin
      hash       = sid[GROUP_BITS-1:0] ^ page[GROUP_BITS-1:0];
      group      = use_alt ? ~hash : hash;
      api        = page[PAGE_W-1 -: API_W];
      spill_slot = page[WAY_BITS-1:0];
   end

endmodule

// File: rtl/hpt_slot_cmp.sv
module hpt_slot_cmp #(
   parameter int unsigned SID_W = 24,
   parameter int unsigned API_W = 6,
   parameter int unsigned PFN_W = 20
) (
   input  logic [hpt_pkg::entry_width(SID_W, API_W, PFN_W)-1:0] entry,
   input  logic [SID_W-1:0]                                     sid,
   input  logic [API_W-1:0]                                     api,
   output logic                                                 usable
);

   localparam int unsigned OFF_API = hpt_pkg::FLAG_W + PFN_W;
   localparam int unsigned OFF_SID = OFF_API + API_W + 1;
   localparam int unsigned OFF_V   = OFF_SID + SID_W;

   logic             e_valid;
   logic [SID_W-1:0] e_sid;
   logic [API_W-1:0] e_api;

   always_comb begin
      e_valid = entry[OFF_V];
      e_sid   = entry[OFF_SID +: SID_W];
      e_api   = entry[OFF_API +: API_W];
      usable  = !e_valid || ((e_sid == sid) && (e_api == api));
   end

endmodule

// File: rtl/hpt_entry_pack.sv
module hpt_entry_pack #(
   parameter int unsigned SID_W = 24,
   parameter int unsigned API_W = 6,
   parameter int unsigned PFN_W = 20
) (
   input  logic [SID_W-1:0]                                     sid,
   input  logic                                                 hsel,
   input  logic [API_W-1:0]                                     api,
   input  logic [PFN_W-1:0]                                     pfn,
   output logic [hpt_pkg::entry_width(SID_W, API_W, PFN_W)-1:0] entry
);

   always_comb begin
      entry = {1'b1, sid, hsel, api, pfn, 1'b0, 1'b0, hpt_pkg::PROT_INIT};
   end

endmodule

// File: rtl/hpt_ctrl.sv
module hpt_ctrl #(
   parameter int unsigned WAYS     = 8,
   parameter int unsigned WAY_BITS = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                usable,
   input  logic [WAY_BITS-1:0] spill_slot,
   output logic                load,
   output logic                busy,
   output logic                done,
   output logic                mem_req,
   output logic                mem_we,
   output logic                alt,
   output logic [WAY_BITS-1:0] slot
);

   import hpt_pkg::*;

   localparam logic [WAY_BITS-1:0] LAST_SLOT = WAY_BITS'(WAYS - 1);

   hpt_state_e          st_q;
   logic [WAY_BITS-1:0] slot_q;
   logic                alt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         slot_q <= '0;
         alt_q  <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  st_q   <= ST_READ;
                  slot_q <= '0;
                  alt_q  <= 1'b0;
               end
            end
            ST_READ:  st_q <= ST_CHECK;
            ST_CHECK: begin
               if (usable) begin
                  st_q <= ST_WRITE;
               end else if (slot_q != LAST_SLOT) begin
                  slot_q <= slot_q + 1'b1;
                  st_q   <= ST_READ;
               end else if (!alt_q) begin
                  alt_q  <= 1'b1;
                  slot_q <= '0;
                  st_q   <= ST_READ;
               end else begin
                  alt_q  <= 1'b0;
                  slot_q <= spill_slot;
                  st_q   <= ST_WRITE;
               end
            end
            ST_WRITE: st_q <= ST_DONE;
            ST_DONE:  st_q <= ST_IDLE;
            default:  st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      load    = (st_q == ST_IDLE) && start;
      busy    = (st_q == ST_READ) || (st_q == ST_CHECK) || (st_q == ST_WRITE);
      done    = (st_q == ST_DONE);
      mem_req = (st_q == ST_READ) || (st_q == ST_WRITE);
      mem_we  = (st_q == ST_WRITE);
      alt     = alt_q;
      slot    = slot_q;
   end

endmodule

// File: rtl/hpt_insert_engine.sv
module hpt_insert_engine #(
   parameter int unsigned VA_W       = 32,
   parameter int unsigned PAGE_LSB   = 12,
   parameter int unsigned PAGE_W     = 16,
   parameter int unsigned API_W      = 6,
   parameter int unsigned SID_W      = 24,
   parameter int unsigned PFN_W      = 20,
   parameter int unsigned CFG_W      = 32,
   parameter int unsigned BASE_LSB   = 16,
   parameter int unsigned GROUP_BITS = 10,
   parameter int unsigned WAYS       = 8,
   localparam int unsigned WAY_BITS  = $clog2(WAYS),
   localparam int unsigned BASE_W    = CFG_W - BASE_LSB,
   localparam int unsigned ADDR_W    = BASE_W + GROUP_BITS + WAY_BITS,
   localparam int unsigned E_W       = hpt_pkg::entry_width(SID_W, API_W, PFN_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [VA_W-1:0]   vaddr,
   input  logic [SID_W-1:0]  seg_id,
   input  logic [PFN_W-1:0]  frame,
   input  logic [CFG_W-1:0]  table_cfg,
   output logic              busy,
   output logic              done,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [E_W-1:0]    mem_wdata,
   input  logic [E_W-1:0]    mem_rdata
);

   generate
      if (WAYS != (1 << WAY_BITS)) begin : g_bad_ways
         $error("WAYS must be a power of two");
      end
      if (GROUP_BITS > PAGE_W || GROUP_BITS > SID_W) begin : g_bad_group
         $error("GROUP_BITS exceeds page index or segment width");
      end
      if (API_W > PAGE_W || PAGE_LSB + PAGE_W > VA_W) begin : g_bad_page
         $error("page index does not fit the virtual address");
      end
      if (BASE_LSB >= CFG_W) begin : g_bad_base
         $error("BASE_LSB must be below CFG_W");
      end
   endgenerate

   logic [PAGE_W-1:0]     page_q;
   logic [SID_W-1:0]      sid_q;
   logic [PFN_W-1:0]      pfn_q;
   logic [BASE_W-1:0]     base_q;

   logic                  load;
   logic                  usable;
   logic                  alt;
   logic [WAY_BITS-1:0]   slot;
   logic [WAY_BITS-1:0]   spill_slot;
   logic [GROUP_BITS-1:0] group;
   logic [API_W-1:0]      api;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= '0;
         sid_q  <= '0;
         pfn_q  <= '0;
         base_q <= '0;
      end else if (load) begin
         page_q <= vaddr[PAGE_LSB +: PAGE_W];
         sid_q  <= seg_id;
         pfn_q  <= frame;
         base_q <= table_cfg[CFG_W-1 -: BASE_W];
      end
   end

   hpt_hash #(
      .PAGE_W(PAGE_W), .SID_W(SID_W), .API_W(API_W),
      .GROUP_BITS(GROUP_BITS), .WAY_BITS(WAY_BITS)
   ) u_hash (
      .page(page_q), .sid(sid_q), .use_alt(alt),
      .group(group), .api(api), .spill_slot(spill_slot)
   );

   hpt_slot_cmp #(
      .SID_W(SID_W), .API_W(API_W), .PFN_W(PFN_W)
   ) u_cmp (
      .entry(mem_rdata), .sid(sid_q), .api(api), .usable(usable)
   );

   hpt_entry_pack #(
      .SID_W(SID_W), .API_W(API_W), .PFN_W(PFN_W)
   ) u_pack (
      .sid(sid_q), .hsel(alt), .api(api), .pfn(pfn_q), .entry(mem_wdata)
   );

   hpt_ctrl #(
      .WAYS(WAYS), .WAY_BITS(WAY_BITS)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .usable(usable),
      .spill_slot(spill_slot), .load(load), .busy(busy), .done(done),
      .mem_req(mem_req), .mem_we(mem_we), .alt(alt), .slot(slot)
   );

   assign mem_addr = {base_q, group, slot};

endmodule

// File: rtl/hpt_insert_checker.sv
module hpt_insert_checker #(
   parameter int unsigned ADDR_W = 29,
   parameter int unsigned E_W    = 56
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [E_W-1:0]    mem_wdata
);

   p_reset_idle_r10: assert property (@(posedge clk)
      !rst_n |=> (!busy && !mem_req && !done));

   p_write_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_wdata[E_W-1] && (mem_wdata[3:0] == 4'b0010)));

   p_done_follows_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |=> done);

   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_quiet_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);

   p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (busy || done));

   p_addr_stable_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |=> $stable(mem_addr[ADDR_W-1 -: 16]));

endmodule

bind hpt_insert_engine hpt_insert_checker #(
   .ADDR_W(ADDR_W), .E_W(E_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
   .mem_wdata(mem_wdata)
);

// File: tb/tb_hpt_insert_engine.sv
module tb_hpt_insert_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] vaddr = '0;
   logic [23:0] seg_id = '0;
   logic [19:0] frame = '0;
   logic [31:0] table_cfg = '0;
   logic        busy, done, mem_req, mem_we;
   logic [28:0] mem_addr;
   logic [55:0] mem_wdata;
   logic [55:0] mem_rdata = '0;

   always #2 clk = ~clk;

   hpt_insert_engine dut (
      .clk(clk), .rst_n(rst_n), .start(start), .vaddr(vaddr),
      .seg_id(seg_id), .frame(frame), .table_cfg(table_cfg),
      .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   int n_checks = 0;
   int n_fail   = 0;

   logic [55:0] mem [8192];
   int          wr_cnt = 0;
   int          done_cnt = 0;
   logic [28:0] wr_addr;
   logic [55:0] wr_data;
   logic        s_req = 1'b0, s_we = 1'b0;
   logic [12:0] s_idx = '0;
   logic [55:0] s_wd = '0;

   always @(negedge clk) begin
      if (mem_req && mem_we) begin
         wr_cnt++;
         wr_addr = mem_addr;
         wr_data = mem_wdata;
      end
      if (done) done_cnt++;
      s_req = mem_req;
      s_we  = mem_we;
      s_idx = mem_addr[12:0];
      s_wd  = mem_wdata;
   end

   always @(posedge clk) begin
      if (s_req) begin
         if (s_we) mem[s_idx] = s_wd;
         else      mem_rdata <= mem[s_idx];
      end
   end

   task automatic check(input bit ok, input string tag,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   typedef struct packed {
      logic [15:0] base;
      logic [31:0] va;
      logic [23:0] sid;
      logic [19:0] pfn;
      logic [1:0]  mode;
   } vec_t;

   localparam vec_t VEC [6] = '{
      '{16'h0010, 32'h0123_4000, 24'h0000A5, 20'h12345, 2'd0},
      '{16'hFFFF, 32'h0FC0_7000, 24'h0003FF, 20'hABCDE, 2'd1},
      '{16'h8000, 32'h0040_1000, 24'h000001, 20'h00F0F, 2'd2},
      '{16'h1234, 32'h0ABC_D000, 24'hFEDCBA, 20'h55AA5, 2'd3},
      '{16'h0001, 32'h003F_F000, 24'h000000, 20'h00001, 2'd2},
      '{16'h7F00, 32'h0000_7000, 24'h000007, 20'hFFFFF, 2'd3}
   };

   function automatic logic [9:0] hash_of(input logic [31:0] va, input logic [23:0] sid);
      return sid[9:0] ^ va[21:12];
   endfunction

   function automatic logic [55:0] foreign(input logic [23:0] sid, input logic [5:0] api);
      return {1'b1, sid ^ 24'h800001, 1'b0, api, 20'h0, 4'h0};
   endfunction

   task automatic fill(input logic [1:0] mode, input logic [31:0] va, input logic [23:0] sid);
      logic [9:0] h1 = hash_of(va, sid);
      logic [9:0] h2 = ~h1;
      logic [5:0] api = va[27:22];
      for (int k = 0; k < 8192; k++) mem[k] = '0;
      if (mode == 2'd1) begin
         for (int s = 0; s < 8; s++) mem[{h1, 3'(s)}] = foreign(sid, api);
         mem[{h1, 3'd5}] = {1'b1, sid, 1'b0, api, 20'h11111, 4'h2};
         mem[{h1, 3'd6}] = '0;
      end else if (mode == 2'd2) begin
         for (int s = 0; s < 8; s++) mem[{h1, 3'(s)}] = foreign(sid, api);
         mem[{h2, 3'd0}] = foreign(sid, api);
         mem[{h2, 3'd1}] = {1'b1, sid, 1'b0, api ^ 6'h1, 20'h0, 4'h0};
         mem[{h2, 3'd2}] = foreign(sid, api);
      end else if (mode == 2'd3) begin
         for (int s = 0; s < 8; s++) begin
            mem[{h1, 3'(s)}] = foreign(sid, api);
            mem[{h2, 3'(s)}] = foreign(sid, api);
         end
      end
   endtask

   task automatic ref_pick(input logic [31:0] va, input logic [23:0] sid,
                           output logic [12:0] idx, output logic hs);
      logic [9:0] h1 = hash_of(va, sid);
      bit found = 0;
      for (int g = 0; g < 2 && !found; g++) begin
         for (int s = 0; s < 8 && !found; s++) begin
            logic [9:0]  grp = (g == 0) ? h1 : ~h1;
            logic [55:0] e   = mem[{grp, 3'(s)}];
            if (!e[55] || (e[54:31] == sid && e[29:24] == va[27:22])) begin
               found = 1;
               idx   = {grp, 3'(s)};
               hs    = (g == 1);
            end
         end
      end
      if (!found) begin
         idx = {h1, va[14:12]};
         hs  = 1'b0;
      end
   endtask

   task automatic pulse_start(input logic [31:0] va, input logic [23:0] sid,
                              input logic [19:0] pfn, input logic [31:0] cfg);
      @(negedge clk);
      vaddr = va; seg_id = sid; frame = pfn; table_cfg = cfg; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(input int d0);
      int n = 0;
      while (done_cnt == d0 && n < 100) begin
         @(negedge clk);
         n++;
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      logic [12:0] eidx;
      logic        eh;
      logic [55:0] edata;
      int w0, d0;

      // R10: reset state
      repeat (3) @(negedge clk);
      check(busy == 1'b0, "R10 busy in reset", 64'(busy), 64'd0);
      check(mem_req == 1'b0, "R10 mem_req in reset", 64'(mem_req), 64'd0);
      check(done == 1'b0, "R10 done in reset", 64'(done), 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < 6; i++) begin
         string mtag;
         fill(VEC[i].mode, VEC[i].va, VEC[i].sid);
         ref_pick(VEC[i].va, VEC[i].sid, eidx, eh);
         edata = {1'b1, VEC[i].sid, eh, VEC[i].va[27:22], VEC[i].pfn, 4'b0010};
         case (VEC[i].mode)
            2'd0:    mtag = "R2 primary slot";
            2'd1:    mtag = "R3 first qualifying slot";
            2'd2:    mtag = "R4 secondary slot";
            default: mtag = "R5 fallback slot";
         endcase
         w0 = wr_cnt;
         d0 = done_cnt;
         pulse_start(VEC[i].va, VEC[i].sid, VEC[i].pfn, {VEC[i].base, 16'hBEEF});
         wait_done(d0);
         check(wr_cnt - w0 == 1, "R8 one write", 64'(wr_cnt - w0), 64'd1);
         check(wr_addr[12:0] == eidx, mtag, 64'(wr_addr[12:0]), 64'(eidx));
         check(wr_addr[28:13] == VEC[i].base, "R7 base bits", 64'(wr_addr[28:13]),
               64'(VEC[i].base));
         check(wr_data == edata, "R6 entry image", 64'(wr_data), 64'(edata));
         check(wr_data[29:24] == VEC[i].va[27:22], "R1 api field",
               64'(wr_data[29:24]), 64'(VEC[i].va[27:22]));
      end

      // R9: start while busy is ignored (long fallback search)
      fill(2'd3, VEC[3].va, VEC[3].sid);
      ref_pick(VEC[3].va, VEC[3].sid, eidx, eh);
      edata = {1'b1, VEC[3].sid, eh, VEC[3].va[27:22], VEC[3].pfn, 4'b0010};
      w0 = wr_cnt;
      d0 = done_cnt;
      pulse_start(VEC[3].va, VEC[3].sid, VEC[3].pfn, {VEC[3].base, 16'h0});
      repeat (4) @(negedge clk);
      pulse_start(32'h0555_5000, 24'h123456, 20'h00077, 32'h9999_0000);
      wait_done(d0);
      check(wr_cnt - w0 == 1, "R9 single write", 64'(wr_cnt - w0), 64'd1);
      check(wr_data == edata && wr_addr == {VEC[3].base, eidx}, "R9 operands kept",
            64'(wr_data), 64'(edata));
      repeat (4) @(negedge clk);
      check(wr_cnt - w0 == 1 && busy == 1'b0, "R9 no restart", 64'(wr_cnt - w0), 64'd1);

      // R10: reset in the middle of an insertion
      fill(2'd3, VEC[5].va, VEC[5].sid);
      w0 = wr_cnt;
      d0 = done_cnt;
      pulse_start(VEC[5].va, VEC[5].sid, VEC[5].pfn, {VEC[5].base, 16'h0});
      repeat (5) @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check(busy == 1'b0, "R10 busy after mid reset", 64'(busy), 64'd0);
      check(mem_req == 1'b0, "R10 mem_req after mid reset", 64'(mem_req), 64'd0);
      rst_n = 1'b1;
      repeat (40) @(negedge clk);
      check(wr_cnt == w0, "R10 no write after abort", 64'(wr_cnt - w0), 64'd0);
      check(done_cnt == d0, "R10 no done after abort", 64'(done_cnt - d0), 64'd0);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule